// File: doc/BRIEF.md
# Cached-head FIFO controller

This block is a four-deep first-in first-out controller. The oldest element sits in a local head register. The remaining elements live in a ring of three external storage cells. The block reaches those cells through two request/acknowledge handshakes, one for writing a cell and one for reading a cell. Producers hand values in through a valid/ready input port. Consumers take the head register from a valid/ready output port.

When the buffer is empty, a new value is loaded straight into the head register and no cell is touched. Any later value is written to the cell that the top pointer selects. Every time a value leaves while more than one is held, the block refills the head by reading the cell that the bottom pointer selects. Cell indices start at 1, and each pointer steps 1, 2, 3, 1, and so on. Only one cell transaction is in flight at a time, and both data ports are quiet while it is pending.

Top module: `hcf_ctrl`

## Requirements
- R1: After reset, out_valid, mem_wr_req and mem_rd_req are 0 and in_ready is 1.
- R2: At most four values are held (head plus three cells). With four held and no output taken, in_ready is 0.
- R3: A value accepted while the buffer is empty appears on out_data with out_valid=1 in the next cycle, and no cell write request is made.
- R4: A value accepted while the buffer holds at least one value raises mem_wr_req in the next cycle, with mem_wr_idx equal to the top pointer and mem_wr_data equal to that value.
- R5: Values leave in the order they were accepted. out_data is the head register whenever out_valid is 1.
- R6: An output transfer made while more than one value is held raises mem_rd_req in the next cycle, with mem_rd_idx equal to the bottom pointer. The returned mem_rd_data becomes the next head.
- R7: An output transfer made while exactly one value is held empties the buffer, with no read request and no pointer change.
- R8: While a cell request is pending, in_ready and out_valid are 0, and mem_wr_req and mem_rd_req are never both 1.
- R9: When out_valid and out_ready are both 1, in_ready is 0, so the output is served first.
- R10: A request stays asserted, with a stable index, until its acknowledge is seen. It drops in the cycle after that acknowledge.
- R11: Both pointers start at 1 and stay within 1..3. Each advances by one per completed handshake and wraps from 3 back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Block can accept a value |
| in_data | input | 2 | Incoming value |
| out_valid | output | 1 | Head register holds a value |
| out_ready | input | 1 | Consumer takes the head |
| out_data | output | 2 | Head register |
| mem_wr_req | output | 1 | Cell write request |
| mem_wr_idx | output | 2 | Cell written (1..3) |
| mem_wr_data | output | 2 | Value written |
| mem_wr_ack | input | 1 | Cell write acknowledge |
| mem_rd_req | output | 1 | Cell read request |
| mem_rd_idx | output | 2 | Cell read (1..3) |
| mem_rd_ack | input | 1 | Cell read acknowledge, qualifies mem_rd_data |
| mem_rd_data | input | 2 | Value returned by the cell |

## Verification
The assertions assume the following about the cell side:
- Each acknowledge is a single-cycle pulse.
- An acknowledge only arrives while its own request is high.
- The read acknowledge carries valid data in the same cycle.

The bench's cell model meets these assumptions. It raises an acknowledge only at a falling edge where it sees the matching request. It holds the acknowledge for exactly one cycle after a chosen wait, and it drives the stored value alongside the read acknowledge.

The bench also changes in_valid, in_data and out_ready only at falling edges. As a result, the ready/valid decisions sampled at the rising edge are stable.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  typedef enum logic [1:0] {
    HC_IDLE  = 2'd0,
    HC_WRITE = 2'd1,
    HC_READ  = 2'd2
  } hc_state_e;
endpackage

// File: rtl/hcf_ring_ptr.sv
module hcf_ring_ptr #(
  parameter int CELLS = 3,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] FIRST = PW'(1);
  localparam logic [PW-1:0] LAST  = PW'(CELLS);

  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (step) ptr_d = (ptr == LAST) ? FIRST : ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= FIRST;
    else if (step) ptr <= ptr_d;
  end

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= FIRST) && (ptr <= LAST));

  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
endmodule

// File: rtl/hcf_seq.sv
module hcf_seq
  import hcf_pkg::*;
#(
  parameter int CAP = 4,
  parameter int OW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          wr_ack,
  input  logic          rd_ack,
  output logic          in_ready,
  output logic          out_valid,
  output logic          wr_req,
  output logic          rd_req,
  output logic          bypass_load,
  output logic          park_load,
  output logic          refill_load,
  output logic          top_step,
  output logic          bot_step,
  output logic [OW-1:0] occ
);
  localparam logic [OW-1:0] CAP_V = OW'(CAP);
  localparam logic [OW-1:0] ONE_V = OW'(1);

  hc_state_e     state, state_d;
  logic [OW-1:0] occ_d;
  logic          occ_en, idle, occ_nz, out_fire, in_fire, wr_done, rd_done;

  assign idle      = (state == HC_IDLE);
  assign occ_nz    = (occ != '0);
  assign out_valid = idle && occ_nz;
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = idle && (occ < CAP_V) && !out_fire;
  assign in_fire   = in_valid && in_ready;
  assign wr_req    = (state == HC_WRITE);
  assign rd_req    = (state == HC_READ);
  assign wr_done   = wr_req && wr_ack;
  assign rd_done   = rd_req && rd_ack;

  assign bypass_load = in_fire && !occ_nz;
  assign park_load   = in_fire && occ_nz;
  assign refill_load = rd_done;
  assign top_step    = wr_done;
  assign bot_step    = rd_done;

  always_comb begin
    state_d = state;
    unique case (state)
      HC_IDLE: begin
        if (out_fire && (occ > ONE_V)) state_d = HC_READ;
        else if (park_load)            state_d = HC_WRITE;
      end
      HC_WRITE: if (wr_ack) state_d = HC_IDLE;
      HC_READ:  if (rd_ack) state_d = HC_IDLE;
      default:  state_d = HC_IDLE;
    endcase
  end

  always_comb begin
    occ_en = 1'b0;
    occ_d  = occ;
    if (out_fire && (occ == ONE_V)) begin
      occ_en = 1'b1;
      occ_d  = '0;
    end else if (bypass_load) begin
      occ_en = 1'b1;
      occ_d  = ONE_V;
    end else if (wr_done) begin
      occ_en = 1'b1;
      occ_d  = occ + ONE_V;
    end else if (rd_done) begin
      occ_en = 1'b1;
      occ_d  = occ - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HC_IDLE;
      occ   <= '0;
    end else begin
      state <= state_d;
      if (occ_en) occ <= occ_d;
    end
  end

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP_V);

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);

  // R10
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> !wr_req);

  // R7
  last_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && (occ == ONE_V) |=> (occ == '0) && !rd_req && !wr_req);
endmodule

// File: rtl/hcf_ctrl.sv
module hcf_ctrl
  import hcf_pkg::*;
#(
  parameter int DW    = 2,
  parameter int CELLS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DW-1:0]                 in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DW-1:0]                 out_data,
  output logic                          mem_wr_req,
  output logic [$clog2(CELLS+1)-1:0]    mem_wr_idx,
  output logic [DW-1:0]                 mem_wr_data,
  input  logic                          mem_wr_ack,
  output logic                          mem_rd_req,
  output logic [$clog2(CELLS+1)-1:0]    mem_rd_idx,
  input  logic                          mem_rd_ack,
  input  logic [DW-1:0]                 mem_rd_data
);
  localparam int CAP = CELLS + 1;
  localparam int PW  = $clog2(CELLS + 1);
  localparam int OW  = $clog2(CAP + 1);

  logic          bypass_load, park_load, refill_load, top_step, bot_step;
  logic [OW-1:0] occ;
  logic [DW-1:0] head_q, head_d, park_q;
  logic          head_en;
  logic [PW-1:0] top_ptr, bot_ptr;

  hcf_seq #(.CAP(CAP), .OW(OW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .wr_ack      (mem_wr_ack),
    .rd_ack      (mem_rd_ack),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .wr_req      (mem_wr_req),
    .rd_req      (mem_rd_req),
    .bypass_load (bypass_load),
    .park_load   (park_load),
    .refill_load (refill_load),
    .top_step    (top_step),
    .bot_step    (bot_step),
    .occ         (occ)
  );

  hcf_ring_ptr #(.CELLS(CELLS), .PW(PW)) top_i (
    .clk (clk), .rst_n (rst_n), .step (top_step), .ptr (top_ptr)
  );

  hcf_ring_ptr #(.CELLS(CELLS), .PW(PW)) bot_i (
    .clk (clk), .rst_n (rst_n), .step (bot_step), .ptr (bot_ptr)
  );

  always_comb begin
    head_en = bypass_load || refill_load;
    head_d  = refill_load ? mem_rd_data : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      park_q <= '0;
    end else begin
      if (head_en)   head_q <= head_d;
      if (park_load) park_q <= in_data;
    end
  end

  assign out_data    = head_q;
  assign mem_wr_idx  = top_ptr;
  assign mem_wr_data = park_q;
  assign mem_rd_idx  = bot_ptr;

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !out_valid |=>
      out_valid && (out_data == $past(in_data)) && !mem_wr_req);

  // R4
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_valid |=>
      mem_wr_req && (mem_wr_data == $past(in_data)) && (mem_wr_idx == $past(top_ptr)));

  // R6
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_ack |=> out_valid && (out_data == $past(mem_rd_data)));

  // R10
  rd_idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> $stable(mem_rd_idx));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req || mem_rd_req) |-> !in_ready && !out_valid);
endmodule

// File: tb/hcf_ctrl_tb_top.sv
module hcf_ctrl_tb_top;
  logic       clk, rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [1:0] in_data, out_data, mem_wr_idx, mem_wr_data, mem_rd_idx, mem_rd_data;
  logic       mem_wr_req, mem_wr_ack, mem_rd_req, mem_rd_ack;

  int n_chk = 0, n_bad = 0;
  logic [1:0] exp_q[$];
  logic [1:0] cells [1:3];
  int exp_top = 1, exp_bot = 1;
  int wr_wait = 0, rd_wait = 0, ack_delay = 0, rd_count = 0, cyc = 0;
  bit auto_rdy = 0, done = 0;

  hcf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_wr_req(mem_wr_req), .mem_wr_idx(mem_wr_idx), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack),
    .mem_rd_req(mem_rd_req), .mem_rd_idx(mem_rd_idx), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cell model and handshake observers
  always @(negedge clk) begin
    cyc++;
    if (auto_rdy) out_ready = cyc[1] ^ cyc[3];
    if (rst_n) begin
      if (mem_wr_req || mem_rd_req)
        check(!in_ready && !out_valid, "R8 quiet while pending", {in_ready, out_valid}, 0);
      if (mem_wr_ack) mem_wr_ack = 0;
      else if (wr_wait > 0 && !mem_wr_req) begin
        check(0, "R10 write request dropped early", 0, 1);
        wr_wait = 0;
      end else if (mem_wr_req) begin
        if (wr_wait < ack_delay) wr_wait++;
        else begin
          check(mem_wr_idx == exp_top, "R4 R11 write index", mem_wr_idx, exp_top);
          cells[mem_wr_idx] = mem_wr_data;
          mem_wr_ack = 1;
          wr_wait = 0;
          exp_top = (exp_top == 3) ? 1 : exp_top + 1;
        end
      end
      if (mem_rd_ack) mem_rd_ack = 0;
      else if (rd_wait > 0 && !mem_rd_req) begin
        check(0, "R10 read request dropped early", 0, 1);
        rd_wait = 0;
      end else if (mem_rd_req) begin
        if (rd_wait < ack_delay) rd_wait++;
        else begin
          check(mem_rd_idx == exp_bot, "R6 R11 read index", mem_rd_idx, exp_bot);
          mem_rd_data = cells[mem_rd_idx];
          mem_rd_ack = 1;
          rd_wait = 0;
          rd_count++;
          exp_bot = (exp_bot == 3) ? 1 : exp_bot + 1;
        end
      end
    end
  end

  // monitor: scoreboard pop on output transfer
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected output", out_data, 0);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R5 output order", out_data, e);
      end
    end
  end

  task automatic send(input logic [1:0] v);
    @(negedge clk);
    in_valid = 1; in_data = v;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(v);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || out_valid) && t < 2000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    in_valid = 0; in_data = 0; out_ready = 0;
    mem_wr_ack = 0; mem_rd_ack = 0; mem_rd_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);
    check(!mem_wr_req && !mem_rd_req, "R1 requests", {mem_wr_req, mem_rd_req}, 0);

    // R3 bypass into empty head
    send(2'd1);
    check(out_valid && out_data == 2'd1, "R3 bypass head", out_data, 1);
    check(!mem_wr_req, "R3 no write on bypass", mem_wr_req, 0);

    // R4 fill the cells
    send(2'd2);
    check(mem_wr_req && mem_wr_data == 2'd2, "R4 write data", mem_wr_data, 2);
    send(2'd3);
    send(2'd1);
    repeat (2) @(negedge clk); #1;
    check(!in_ready, "R2 full blocks input", in_ready, 0);
    check(out_valid && out_data == 2'd1, "R5 head while full", out_data, 1);

    // R6 R7 drain
    out_ready = 1;
    drain();
    check(rd_count == 3, "R7 no read on last output", rd_count, 3);
    check(!out_valid && in_ready, "R7 empty after drain", {out_valid, in_ready}, 1);

    // R9 output served first
    out_ready = 0;
    send(2'd2);
    @(negedge clk);
    in_valid = 1; in_data = 2'd3; out_ready = 1;
    #1;
    check(!in_ready, "R9 output priority", in_ready, 0);
    @(posedge clk); #1;
    in_valid = 0;
    drain();
    send(2'd3);
    drain();

    // R10 R11 slow acknowledges, pointer wrap
    ack_delay = 2;
    out_ready = 0;
    for (int i = 0; i < 4; i++) send(2'(i % 3 + 1));
    out_ready = 1;
    drain();
    check(exp_top == exp_bot, "R11 pointers meet when empty", exp_top, exp_bot);

    // mixed stream
    auto_rdy = 1;
    for (int i = 0; i < 60; i++) begin
      ack_delay = i % 3;
      send(2'((i * 7) % 3 + 1));
    end
    auto_rdy = 0;
    out_ready = 1;
    drain();
    check(exp_q.size() == 0, "R5 all values delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule